// File: doc/BRIEF.md
# Network Loop-Code Detector

This block watches a serial receive stream, one bit for each enable pulse, for the two repeating in-band codes used to request and release a far-end loopback. The loop-up code repeats the 5-bit cycle 00001 and the loop-down code repeats the 3-bit cycle 001. Both codes are recognised at any bit phase. A code counts only after it has been present without a break for longer than a qualification window. The window is a parameter counted in received bit periods, so a multi-second hold time becomes a plain counter limit.

A 2-bit mode input selects how qualified codes are used. In manual mode a status output follows the presence of either qualified code. In automatic mode the block runs a handshake: a qualified loop-up latches both the status bit and a remote-loopback control output. Both then stay set, even after the loop-up code stops, until a qualified loop-down code releases them. Whenever the status bit changes value and interrupts are enabled, the block raises a one-cycle interrupt pulse.

Top module: `loopcode_detector`

## Requirements
- R1: The loop-up code is any stream that repeats with period 5 and holds exactly one 1 in every 5 consecutive bits (00001 in some rotation). In manual mode (mode 01 or 10), the status output rises once QUAL_BITS+1 consecutive received bits each complete such a 5-bit window.
- R2: The loop-down code is any stream that repeats with period 3 and holds exactly one 1 in every 3 consecutive bits (001 in some rotation). In manual mode it sets the status output under the same rule as R1.
- R3: Detection requires a run strictly longer than the qualification window. After QUAL_BITS matching bit periods the status output is still 0.
- R4: In manual mode the status output returns to 0 after the first received bit that breaks the qualified code.
- R5: Mode 00 disables detection. It holds the status and remote-loopback outputs at 0 and clears all pattern history and timers. Remote loopback is never asserted in the manual modes.
- R6: With irq_en at 1, every change of the status output comes with a one-cycle pulse on irq_o in the same cycle. With irq_en at 0, irq_o stays at 0.
- R7: Entering automatic mode (mode 11) clears the status output and arms the detector for the loop-up code only. A qualified loop-down code does not set the status output in that state.
- R8: In automatic mode a qualified loop-up code sets the status output and the remote-loopback output in the same cycle.
- R9: Once remote loopback is latched, the status and remote-loopback outputs stay at 1 after the loop-up code stops.
- R10: While remote loopback is latched, a qualified loop-down code clears the status and remote-loopback outputs together, and raises an interrupt when enabled.
- R11: A mode change that leaves the status value unchanged raises no interrupt.
- R12: Qualification does not depend on the bit phase at which a code begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies rx_bit as one received bit period |
| rx_bit | input | 1 | Received data bit |
| mode | input | 2 | 00 off, 01 or 10 manual, 11 automatic |
| irq_en | input | 1 | Enables the interrupt pulse |
| status_o | output | 1 | Loop-code status bit |
| rloop_o | output | 1 | Remote-loopback control |
| irq_o | output | 1 | One-cycle interrupt pulse on a status change |

## Verification
The hardest state to reach from the ports is the latched loopback held with no code present, followed by its exact release boundary. The bench arms automatic mode and qualifies loop-up. It then sends a long run of zeros, which matches neither code. After that it restarts a loop-down stream and stops one bit short of qualification, then adds the final bit, so that it shows the status holding and then releasing at the exact bit count. A down code sent while the block is armed for up, and a mode change that leaves the status unchanged, check the paths that must not fire.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  typedef enum logic [1:0] {
    LC_OFF   = 2'b00,
    LC_MAN_A = 2'b01,
    LC_MAN_B = 2'b10,
    LC_AUTO  = 2'b11
  } lc_mode_e;

  localparam int UP_LEN = 5;
  localparam int DN_LEN = 3;
  localparam logic [UP_LEN-1:0] UP_CODE = 5'b00001;
  localparam logic [DN_LEN-1:0] DN_CODE = 3'b001;
endpackage

// File: rtl/lcd_match.sv
module lcd_match #(
  parameter int CODE_LEN = 5,
  parameter logic [CODE_LEN-1:0] PATTERN = '0
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic bit_en,
  input  logic rx_bit,
  output logic hit
);
  localparam int FW = $clog2(CODE_LEN + 1);
  localparam logic [2*CODE_LEN-1:0] DBL = {PATTERN, PATTERN};
  localparam logic [FW-1:0] FULL = FW'(CODE_LEN - 1);

  logic [CODE_LEN-2:0] hist;
  logic [FW-1:0]       fill;
  logic [CODE_LEN-1:0] win;
  logic [CODE_LEN-1:0] rot_hit;

  assign win = {hist, rx_bit};

  // one comparator for every rotation of the code
  for (genvar k = 0; k < CODE_LEN; k++) begin : g_rot
    assign rot_hit[k] = (win == DBL[k +: CODE_LEN]);
  end

  assign hit = (fill == FULL) && (|rot_hit);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hist <= '0;
      fill <= '0;
    end else if (bit_en) begin
      hist <= win[CODE_LEN-2:0];
      if (fill != FULL) fill <= fill + 1'b1;
    end
  end
endmodule

// File: rtl/lcd_qual.sv
module lcd_qual #(
  parameter int QUAL_BITS = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic bit_en,
  input  logic hit,
  output logic qual_o
);
  localparam int CW = $clog2(QUAL_BITS + 2);
  localparam logic [CW-1:0] LIMIT = CW'(QUAL_BITS + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (bit_en) begin
      if (!hit)             cnt <= '0;
      else if (cnt != LIMIT) cnt <= cnt + 1'b1;
    end
  end

  assign qual_o = (cnt == LIMIT);

  // R4: a bit that breaks the code drops qualification at once
  a_r4_break_drops: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !hit) |=> !qual_o);
  // R3: qualification only appears on a received bit
  a_r3_rise_on_bit: assert property (@(posedge clk) disable iff (rst)
    $rose(qual_o) |-> $past(bit_en && hit));
endmodule

// File: rtl/lcd_ctrl.sv
module lcd_ctrl
  import lcd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  lc_mode_e mode,
  input  logic     irq_en,
  input  logic     up_q,
  input  logic     dn_q,
  output logic     clr_o,
  output logic     status_o,
  output logic     rloop_o,
  output logic     irq_o
);
  lc_mode_e mode_q;
  logic     status_d, rloop_d, armed_dn_d, armed_dn;
  logic     entering_auto;

  assign entering_auto = (mode == LC_AUTO) && (mode_q != LC_AUTO);
  assign clr_o = (mode == LC_OFF) || entering_auto;

  always_comb begin
    status_d   = status_o;
    rloop_d    = rloop_o;
    armed_dn_d = armed_dn;
    if (mode == LC_OFF || entering_auto) begin
      status_d   = 1'b0;
      rloop_d    = 1'b0;
      armed_dn_d = 1'b0;
    end else if (mode == LC_AUTO) begin
      if (!armed_dn && up_q) begin
        status_d   = 1'b1;
        rloop_d    = 1'b1;
        armed_dn_d = 1'b1;
      end else if (armed_dn && dn_q) begin
        status_d   = 1'b0;
        rloop_d    = 1'b0;
        armed_dn_d = 1'b0;
      end
    end else begin
      status_d   = up_q | dn_q;
      rloop_d    = 1'b0;
      armed_dn_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= LC_OFF;
      status_o <= 1'b0;
      rloop_o  <= 1'b0;
      armed_dn <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      mode_q   <= mode;
      status_o <= status_d;
      rloop_o  <= rloop_d;
      armed_dn <= armed_dn_d;
      irq_o    <= irq_en && (status_d != status_o);
    end
  end

  // R5: off mode forces both outputs low
  a_r5_off_clears: assert property (@(posedge clk) disable iff (rst)
    (mode == LC_OFF) |=> (!status_o && !rloop_o));
  // R5: loopback only ever follows automatic mode
  a_r5_rloop_auto_only: assert property (@(posedge clk) disable iff (rst)
    (mode != LC_AUTO) |=> !rloop_o);
  // R8: loopback never stands without the status bit
  a_r8_rloop_has_status: assert property (@(posedge clk) disable iff (rst)
    rloop_o |-> status_o);
  // R6: an interrupt marks a real status change
  a_r6_irq_on_change: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (status_o != $past(status_o)));
  // R6: no interrupt while disabled
  a_r6_irq_gated: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq_o);
endmodule

// File: rtl/loopcode_detector.sv
module loopcode_detector
  import lcd_pkg::*;
#(
  parameter int QUAL_BITS = 7720000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic       rx_bit,
  input  logic [1:0] mode,
  input  logic       irq_en,
  output logic       status_o,
  output logic       rloop_o,
  output logic       irq_o
);
  logic clr, up_hit, dn_hit, up_q, dn_q;

  lcd_match #(.CODE_LEN(UP_LEN), .PATTERN(UP_CODE)) u_up_match (
    .clk(clk), .rst(rst), .clr(clr), .bit_en(bit_en), .rx_bit(rx_bit), .hit(up_hit));
  lcd_match #(.CODE_LEN(DN_LEN), .PATTERN(DN_CODE)) u_dn_match (
    .clk(clk), .rst(rst), .clr(clr), .bit_en(bit_en), .rx_bit(rx_bit), .hit(dn_hit));

  lcd_qual #(.QUAL_BITS(QUAL_BITS)) u_up_qual (
    .clk(clk), .rst(rst), .clr(clr), .bit_en(bit_en), .hit(up_hit), .qual_o(up_q));
  lcd_qual #(.QUAL_BITS(QUAL_BITS)) u_dn_qual (
    .clk(clk), .rst(rst), .clr(clr), .bit_en(bit_en), .hit(dn_hit), .qual_o(dn_q));

  lcd_ctrl u_ctrl (
    .clk(clk), .rst(rst), .mode(lc_mode_e'(mode)), .irq_en(irq_en),
    .up_q(up_q), .dn_q(dn_q), .clr_o(clr),
    .status_o(status_o), .rloop_o(rloop_o), .irq_o(irq_o));
endmodule

// File: tb/loopcode_detector_bench.sv
module loopcode_detector_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 20;

  logic clk = 1'b0, rst = 1'b1, bit_en = 1'b0, rx_bit = 1'b0, irq_en = 1'b0;
  logic [1:0] mode = 2'b00;
  logic status_o, rloop_o, irq_o;
  int checks = 0, errors = 0, irq_cnt = 0, pos = 0, base = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loopcode_detector #(.QUAL_BITS(Q)) u_loopcode_detector (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit), .mode(mode),
    .irq_en(irq_en), .status_o(status_o), .rloop_o(rloop_o), .irq_o(irq_o));

  always @(negedge clk) if (!rst && irq_o) irq_cnt++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_code(input int len, input int n);
    for (int i = 0; i < n; i++) begin
      rx_bit = ((pos % len) == len - 1); bit_en = 1'b1; pos++;
      @(negedge clk);
    end
    bit_en = 1'b0;
    idle(3);
  endtask

  task automatic send_const(input logic b, input int n);
    for (int i = 0; i < n; i++) begin
      rx_bit = b; bit_en = 1'b1; @(negedge clk);
    end
    bit_en = 1'b0;
    idle(3);
  endtask

  task automatic go_off();
    mode = 2'b00; idle(2); pos = 0;
  endtask

  task automatic t_reset();
    idle(3); rst = 1'b0; idle(1);
    check("R5 reset status", status_o, 0);
    check("R5 reset rloop", rloop_o, 0);
    check("R6 reset irq", irq_o, 0);
  endtask

  task automatic t_manual_up();
    go_off(); irq_en = 1'b1; mode = 2'b01; idle(1); base = irq_cnt;
    send_code(5, Q + 4);
    check("R3 up one short", status_o, 0);
    send_code(5, 1);
    check("R1 up qualified", status_o, 1);
    check("R5 no loop in manual", rloop_o, 0);
    check("R6 irq on rise", irq_cnt - base, 1);
    send_const(1'b1, 1);
    check("R4 break clears", status_o, 0);
    check("R6 irq on fall", irq_cnt - base, 2);
  endtask

  task automatic t_manual_dn();
    go_off(); irq_en = 1'b1; mode = 2'b10; idle(1); pos = 1; base = irq_cnt;
    send_code(3, Q + 2);
    check("R3 down one short", status_o, 0);
    send_code(3, 1);
    check("R2 R12 down qualified at offset phase", status_o, 1);
    mode = 2'b01; idle(3);
    check("R11 manual swap keeps status", status_o, 1);
    check("R11 manual swap no irq", irq_cnt - base, 1);
    mode = 2'b00; idle(3);
    check("R5 off clears status", status_o, 0);
    mode = 2'b01; idle(3);
    check("R5 timers reset", status_o, 0);
  endtask

  task automatic t_irq_off();
    go_off(); irq_en = 1'b0; mode = 2'b01; idle(1); base = irq_cnt;
    send_code(5, Q + 5);
    check("R6 status rises without irq", status_o, 1);
    send_const(1'b1, 1);
    check("R6 irq gated", irq_cnt - base, 0);
  endtask

  task automatic t_auto();
    go_off(); irq_en = 1'b1; mode = 2'b11; idle(1); base = irq_cnt;
    send_code(3, Q + 10);
    check("R7 down ignored while armed for up", status_o, 0);
    check("R7 no loop", rloop_o, 0);
    go_off(); mode = 2'b11; idle(1); base = irq_cnt;
    send_code(5, Q + 4);
    check("R3 auto up one short", status_o, 0);
    send_code(5, 1);
    check("R8 status set", status_o, 1);
    check("R8 loop set", rloop_o, 1);
    check("R6 auto irq", irq_cnt - base, 1);
    send_const(1'b0, 50);
    check("R9 status held", status_o, 1);
    check("R9 loop held", rloop_o, 1);
    pos = 0;
    send_code(3, Q + 2);
    check("R10 held one short", rloop_o, 1);
    send_code(3, 1);
    check("R10 status cleared", status_o, 0);
    check("R10 loop cleared", rloop_o, 0);
    check("R10 irq", irq_cnt - base, 2);
    mode = 2'b00; idle(3);
    check("R11 off with status low no irq", irq_cnt - base, 2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_manual_up();
    t_manual_dn();
    t_irq_off();
    t_auto();
    finish_run();
  end
endmodule